// File: doc/BRIEF.md
# External Bus Cycle Sequencer with Idle-State Insertion

This block runs read and write cycles on an external memory bus. Each request carries an address. The top address bits select one of eight chip-select areas, and a per-area setting gives that area a two-state cycle (T1, T2) or a three-state cycle (T1, T2, T3). The sequencer drives the address bus, the active-low chip selects, the active-low read and write strobes, and the write data with its output enable. It captures read data at the end of the final state.

A slow device can keep driving the data bus for a while after its cycle ends. To stop that device from clashing with the next one, the sequencer keeps a record of the type and area of the last cycle it ran. Before it starts a new cycle it checks that record. Where the configured conditions hold, it places one quiet state, the gap state, ahead of T1. Two enable bits control the insertion: one for a read that follows a read to another area, and one for a write that follows a read. Both enable bits are held in a register that loads from a configuration strobe and resets to 1. The read-after-read case applies only while the advanced-addressing mode input is high.

The state machine has five states:
- FREE: no cycle is running.
- GAP: the inserted idle state.
- T1, T2 and T3: the bus states of a cycle.

The transitions are:
- FREE→GAP or FREE→T1 when a request is accepted.
- GAP→T1.
- T1→T2.
- T2→T3 when the area uses three states.
- From the final state (T2 or T3): to GAP or T1 when a new request is accepted, otherwise to FREE.

Top module: `ebus_seq`

## Requirements
- R1: During every state from T1 to the final state, the chip select of the area given by address bits [15:13] is low and all other chip selects are high. `bus_addr` equals the accepted address throughout.
- R2: A cycle lasts three states when `cfg_area_3st[area]` is 1 and two states when it is 0.
- R3: In T1 both strobes are high. From T2 through the final state, `bus_rd_n` is low for a read and `bus_wr_n` is low for a write. The two strobes are never low together. For a write, `bus_doe` is high and `bus_dout` carries the write data from T1 through the final state. For a read, `bus_doe` stays low.
- R4: For a read, `bus_din` is sampled at the end of the final state. It appears on `rsp_rdata` with `rsp_valid` high for exactly one cycle on the next clock. `rsp_valid` stays low after writes.
- R5: A read that follows a read to a different area gets exactly one GAP state before T1 when both the read-after-read enable and `cfg_adv_mode` are 1.
- R6: When either the read-after-read enable or `cfg_adv_mode` is 0, a read that follows a read to a different area gets no GAP state.
- R7: A write that follows a read gets one GAP state when the write-after-read enable is 1, and none when it is 0. This works independently of the read-after-read enable.
- R8: A read that follows a read to the same area gets no GAP state. A cycle of either type that follows a write gets no GAP state.
- R9: In GAP and FREE, all chip selects and both strobes are high, `bus_doe` is low, and in GAP `req_ready` is low.
- R10: Both enables reset to 1. A pulse on `cfg_we` loads `cfg_rr_gap_d` into the read-after-read enable and `cfg_wr_gap_d` into the write-after-read enable.
- R11: After reset the history is empty, so the first cycle never gets a GAP state, whatever its type.
- R12: `req_ready` is high in FREE and in the final state. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. A request offered during the final state starts GAP or T1 on the next state, with no FREE state in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address; bits [15:13] select the area |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 8 | Captured read data |
| cfg_we | input | 1 | Load strobe for the two enables |
| cfg_rr_gap_d | input | 1 | Read-after-read enable value to load |
| cfg_wr_gap_d | input | 1 | Write-after-read enable value to load |
| cfg_adv_mode | input | 1 | Advanced addressing mode; gates read-after-read insertion |
| cfg_area_3st | input | 8 | Per-area select: 1 = three-state cycle |
| bus_addr | output | 16 | External address |
| bus_cs_n | output | 8 | Active-low chip selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_dout | output | 8 | Write data to the bus |
| bus_doe | output | 1 | Write data output enable |
| bus_din | input | 8 | Read data from the bus |

## Verification
Counting from the clock edge that accepts a request, the first state after it is either GAP or T1. The bench therefore counts quiet states from the first falling edge after acceptance, and expects 0 or 1 according to its own model of the history and the enables. It then counts active states until `req_ready` rises, expecting 2 or 3. `rsp_valid` is due on the falling edge that follows the final state. To keep to that timing, a monitor arms a pending flag at the final state, checks that falling edge, and flags any stray pulse. All bus values are sampled on falling edges, and each next request is raised at the final state's falling edge, so back-to-back timing is exercised across every pair of previous and next type, same and different area, and every enable combination.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

    typedef enum logic [2:0] {
        ST_FREE,
        ST_GAP,
        ST_T1,
        ST_T2,
        ST_T3
    } bus_st_e;

endpackage

// File: rtl/ebus_area_dec.sv
module ebus_area_dec #(
    parameter int N_AREA = 8,
    parameter int AREA_W = 3
) (
    input  logic [AREA_W-1:0] addr_hi,
    input  logic [N_AREA-1:0] area_3st,
    output logic [AREA_W-1:0] area,
    output logic              three_st
);

    // the upper address bits name the area directly
    always_comb begin
        area     = addr_hi;
        three_st = area_3st[addr_hi];
    end

endmodule

// File: rtl/ebus_gap_cfg.sv
module ebus_gap_cfg (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic rr_d,
    input  logic wr_d,
    output logic rr_en,
    output logic wr_en
);

    // both enables come out of reset set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_en <= 1'b1;
            wr_en <= 1'b1;
        end else if (we) begin
            rr_en <= rr_d;
            wr_en <= wr_d;
        end
    end

endmodule

// File: rtl/ebus_hist.sv
module ebus_hist #(
    parameter int AREA_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              new_write,
    input  logic [AREA_W-1:0] new_area,
    input  logic              rr_en,
    input  logic              wr_en,
    input  logic              adv_mode,
    output logic              need_gap
);

    logic              seen_q;
    logic              last_wr_q;
    logic [AREA_W-1:0] last_area_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q      <= 1'b0;
            last_wr_q   <= 1'b0;
            last_area_q <= '0;
        end else if (take) begin
            seen_q      <= 1'b1;
            last_wr_q   <= new_write;
            last_area_q <= new_area;
        end
    end

    // only a preceding read can leave a slow driver on the data bus
    always_comb begin
        need_gap = 1'b0;
        if (seen_q && !last_wr_q) begin
            if (new_write)
                need_gap = wr_en;
            else
                need_gap = rr_en && adv_mode && (new_area != last_area_q);
        end
    end

endmodule

// File: rtl/ebus_seq.sv
module ebus_seq #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int N_AREA = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              cfg_we,
    input  logic              cfg_rr_gap_d,
    input  logic              cfg_wr_gap_d,
    input  logic              cfg_adv_mode,
    input  logic [N_AREA-1:0] cfg_area_3st,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [N_AREA-1:0] bus_cs_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [DATA_W-1:0] bus_din
);
    import ebus_pkg::*;

    localparam int AREA_W = (N_AREA > 1) ? $clog2(N_AREA) : 1;

    bus_st_e           state;
    bus_st_e           nxt;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    logic              cur_write;
    logic              cur_3st;
    logic [AREA_W-1:0] cur_area;
    logic [AREA_W-1:0] req_area;
    logic              req_3st;
    logic              need_gap;
    logic              rr_en;
    logic              wr_en;
    logic              is_final;
    logic              accept;
    logic [N_AREA-1:0] cs_sel;

    ebus_area_dec #(.N_AREA(N_AREA), .AREA_W(AREA_W)) u_dec (
        .addr_hi  (req_addr[ADDR_W-1 -: AREA_W]),
        .area_3st (cfg_area_3st),
        .area     (req_area),
        .three_st (req_3st)
    );

    ebus_gap_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .rr_d  (cfg_rr_gap_d),
        .wr_d  (cfg_wr_gap_d),
        .rr_en (rr_en),
        .wr_en (wr_en)
    );

    ebus_hist #(.AREA_W(AREA_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (accept),
        .new_write (req_write),
        .new_area  (req_area),
        .rr_en     (rr_en),
        .wr_en     (wr_en),
        .adv_mode  (cfg_adv_mode),
        .need_gap  (need_gap)
    );

    generate
        for (genvar g = 0; g < N_AREA; g++) begin : g_cs
            assign cs_sel[g] = (cur_area == AREA_W'(g));
        end
    endgenerate

    assign is_final  = (state == ST_T3) || (state == ST_T2 && !cur_3st);
    assign req_ready = (state == ST_FREE) || is_final;
    assign accept    = req_valid && req_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_FREE;
        else
            state <= nxt;
    end

    // next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_FREE: if (accept) nxt = need_gap ? ST_GAP : ST_T1;
            ST_GAP:  nxt = ST_T1;
            ST_T1:   nxt = ST_T2;
            ST_T2: begin
                if (cur_3st)
                    nxt = ST_T3;
                else if (accept)
                    nxt = need_gap ? ST_GAP : ST_T1;
                else
                    nxt = ST_FREE;
            end
            ST_T3: begin
                if (accept)
                    nxt = need_gap ? ST_GAP : ST_T1;
                else
                    nxt = ST_FREE;
            end
            default: nxt = ST_FREE;
        endcase
    end

    // request held for the whole cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            cur_wdata <= '0;
            cur_write <= 1'b0;
            cur_3st   <= 1'b0;
            cur_area  <= '0;
        end else if (accept) begin
            cur_addr  <= req_addr;
            cur_wdata <= req_wdata;
            cur_write <= req_write;
            cur_3st   <= req_3st;
            cur_area  <= req_area;
        end
    end

    // read data taken at the close of the final state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= is_final && !cur_write;
            if (is_final && !cur_write)
                rsp_rdata <= bus_din;
        end
    end

    // bus pins from the state
    always_comb begin
        bus_addr = cur_addr;
        bus_dout = cur_wdata;
        bus_cs_n = '1;
        bus_rd_n = 1'b1;
        bus_wr_n = 1'b1;
        bus_doe  = 1'b0;
        unique case (state)
            ST_FREE, ST_GAP: begin
            end
            ST_T1: begin
                bus_cs_n = ~cs_sel;
                bus_doe  = cur_write;
            end
            ST_T2, ST_T3: begin
                bus_cs_n = ~cs_sel;
                bus_rd_n = cur_write;
                bus_wr_n = !cur_write;
                bus_doe  = cur_write;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/ebus_seq_chk.sv
module ebus_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int N_AREA = 8
) (
    input logic              clk,
    input logic              rst_n,
    input ebus_pkg::bus_st_e st,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N_AREA-1:0] bus_cs_n,
    input logic              bus_rd_n,
    input logic              bus_wr_n,
    input logic              bus_doe
);
    import ebus_pkg::*;

    logic act;
    assign act = |(~bus_cs_n);

    // R1
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_cs_n));

    // R1
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && $past(act) && !$past(req_ready)) |-> ($stable(bus_addr) && $stable(bus_cs_n)));

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    // R3
    oe_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> (bus_rd_n && $countones(~bus_cs_n) == 1));

    // R4
    rsp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!bus_rd_n && req_ready));

    // R9
    gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_GAP) |-> (!act && bus_rd_n && bus_wr_n && !bus_doe && !req_ready));

    // R12
    final_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && act) |-> (!bus_rd_n || !bus_wr_n));

endmodule

bind ebus_seq ebus_seq_chk #(.ADDR_W(ADDR_W), .N_AREA(N_AREA)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (state),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .bus_addr  (bus_addr),
    .bus_cs_n  (bus_cs_n),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n),
    .bus_doe   (bus_doe)
);

// File: tb/test_ebus_seq.sv
`timescale 1ns/1ps
module test_ebus_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic        cfg_we = 1'b0;
    logic        cfg_rr_gap_d = 1'b1;
    logic        cfg_wr_gap_d = 1'b1;
    logic        cfg_adv_mode = 1'b1;
    logic [7:0]  cfg_area_3st = 8'b1010_0110;
    logic [15:0] bus_addr;
    logic [7:0]  bus_cs_n;
    logic        bus_rd_n;
    logic        bus_wr_n;
    logic [7:0]  bus_dout;
    logic        bus_doe;
    logic [7:0]  bus_din;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model of history and enables
    bit m_seen = 0;
    bit m_wr = 0;
    int m_area = 0;
    bit c_rr = 1;
    bit c_wr = 1;
    bit back = 0;
    logic [7:0] exp_rd = '0;
    bit rd_pend = 0;

    always #2.5 clk = ~clk;

    assign bus_din = bus_rd_n ? 8'h00 : (bus_addr[7:0] ^ bus_addr[15:8]);

    ebus_seq i_ebus_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .cfg_we(cfg_we), .cfg_rr_gap_d(cfg_rr_gap_d), .cfg_wr_gap_d(cfg_wr_gap_d),
        .cfg_adv_mode(cfg_adv_mode), .cfg_area_3st(cfg_area_3st),
        .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_din(bus_din)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, expv, $time);
        end
    endtask

    // R4: one rsp_valid pulse on the falling edge after a read's final state
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_pend) begin
                chk(rsp_valid && rsp_rdata == exp_rd, "R4", int'(rsp_rdata), int'(exp_rd));
                rd_pend <= 0;
            end else if (rsp_valid) begin
                chk(0, "R4", 1, 0);
            end
        end
    end

    task automatic set_cfg(input bit rr, input bit wr);
        @(negedge clk);
        cfg_we = 1'b1; cfg_rr_gap_d = rr; cfg_wr_gap_d = wr;
        @(negedge clk);
        cfg_we = 1'b0;
        c_rr = rr; c_wr = wr;
        back = 0;
    endtask

    task automatic do_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_seen = 0; c_rr = 1; c_wr = 1; back = 0;
    endtask

    task automatic run(input bit w, input int area, input int lo, input int gap);
        logic [15:0] a;
        logic [7:0]  wd;
        logic [7:0]  mask;
        bit          eg;
        string       rq;
        int          idl;
        int          act;
        int          exp_len;
        bit          ok_q;
        bit          ok_cs;
        bit          ok_st;
        a    = {area[2:0], lo[12:0]};
        wd   = a[7:0] ^ 8'h3C;
        mask = 8'(1) << area;
        eg = m_seen && !m_wr && (w ? c_wr : (c_rr && cfg_adv_mode && area != m_area));
        if (!m_seen)              rq = "R11";
        else if (m_wr)            rq = "R8";
        else if (w)               rq = "R7";
        else if (area == m_area)  rq = "R8";
        else if (c_rr && cfg_adv_mode) rq = "R5";
        else                      rq = "R6";
        if (gap > 0) back = 0;
        repeat (gap) @(negedge clk);
        req_write = w; req_addr = a; req_wdata = wd; req_valid = 1'b1;
        // R12: offered in the final state, taken at once
        if (back) chk(req_ready, "R12", int'(req_ready), 1);
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
        m_seen = 1; m_wr = w; m_area = area;
        @(negedge clk);
        idl = 0; ok_q = 1;
        while (&bus_cs_n && idl < 4) begin
            if (!bus_rd_n || !bus_wr_n || bus_doe || req_ready) ok_q = 0;
            idl++;
            @(negedge clk);
        end
        chk(idl == int'(eg), rq, idl, int'(eg));
        if (idl > 0) chk(ok_q, "R9", int'(ok_q), 1);
        act = 0; ok_cs = 1; ok_st = 1;
        forever begin
            act++;
            if (bus_cs_n != ~mask || bus_addr != a) ok_cs = 0;
            if (act == 1) begin
                if (!bus_rd_n || !bus_wr_n) ok_st = 0;
            end else begin
                if (bus_rd_n != w || bus_wr_n != !w) ok_st = 0;
            end
            if (bus_doe != w) ok_st = 0;
            if (w && bus_dout != wd) ok_st = 0;
            if (req_ready || act >= 4) break;
            @(negedge clk);
        end
        exp_len = cfg_area_3st[area] ? 3 : 2;
        chk(act == exp_len, "R2", act, exp_len);
        chk(ok_cs, "R1", int'(ok_cs), 1);
        chk(ok_st, "R3", int'(ok_st), 1);
        if (!w) begin
            exp_rd  <= a[7:0] ^ a[15:8];
            rd_pend <= 1;
        end
        back = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 R12: quiet bus and ready after reset
        chk(&bus_cs_n && bus_rd_n && bus_wr_n && !bus_doe, "R9", int'(bus_cs_n), 255);
        chk(req_ready && !rsp_valid, "R12", int'(req_ready), 1);

        // R11 first cycle, then R10 default enables
        run(1, 2, 13'h0011, 0);
        run(0, 0, 13'h0102, 0);
        run(0, 3, 13'h0203, 0);   // R10: read-after-read on by default
        run(1, 3, 13'h0304, 0);   // R10: write-after-read on by default

        // sweep every enable combination and every previous/next pair
        for (int c = 0; c < 8; c++) begin
            cfg_adv_mode = c[2];
            set_cfg(c[0], c[1]);
            for (int pa = 0; pa < 8; pa++) begin
                for (int k = 0; k < 2; k++) begin
                    for (int pw = 0; pw < 2; pw++) begin
                        for (int nw = 0; nw < 2; nw++) begin
                            int na;
                            na = (k == 1) ? ((pa + 3) % 8) : pa;
                            run(pw[0], pa, (c * 37 + pa * 11 + k) & 13'h1FFF, (pa % 3 == 0) ? 2 : 0);
                            run(nw[0], na, (pa * 53 + nw * 7 + 5) & 13'h1FFF, 0);
                        end
                    end
                end
            end
        end

        // R11 and R10 after a second reset
        cfg_adv_mode = 1'b1;
        set_cfg(0, 0);
        run(0, 4, 13'h0aaa, 0);
        do_reset();
        run(1, 1, 13'h0bbb, 0);   // R11: no gap despite earlier read
        run(0, 2, 13'h0ccc, 0);
        run(0, 5, 13'h0ddd, 0);   // R10: enable back to 1 after reset
        run(1, 5, 13'h0eee, 0);   // R10
        repeat (4) @(negedge clk);

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule